// File: doc/BRIEF.md
# Key-Sequence Write Protection Gate

This block guards a bank of configuration registers against stray writes. It sits on a simple bus write port and produces a write-enable qualifier for the protected bank. That qualifier is raised only while the bank is open. To open the bank, software writes two fixed key bytes, in a fixed order, to one dedicated key address. Any other value written to that address closes the bank again at once. A deliberate dummy key is the usual way to close it after a configuration session.

The gate also masks the read path. A read of the key address always returns zero, so the key bytes cannot be recovered. Reads of every other address pass the bank's data through unchanged. The bus address and data go straight to the protected registers. This block decides only whether the write strobe reaches them.

Top module: `wp_key_gate`

## Requirements
- R1: While reset is low at a clock edge, the gate is closed after that edge (`unlocked` = 0).
- R2: A key-address write of 0xCA followed by a key-address write of 0x53 opens the gate. `unlocked` rises on the edge that takes the second key. The key address defaults to 0x24.
- R3: After 0xCA has been taken, a key-address write of any value other than 0x53 (0xCA included) closes the gate. A fresh 0xCA is then needed.
- R4: While closed, a key-address write of any value other than 0xCA leaves the gate closed and does not start the sequence.
- R5: While open, any key-address write (0xFF, 0xCA or 0x53 included) closes the gate on that edge.
- R6: Only data bits [7:0] of a key-address write are compared. Bits above 7 have no effect on the sequence.
- R7: `bank_wr_en` is high in the same cycle as a write to a non-key address while the gate is open. It is low whenever the gate is closed or half-way through the sequence.
- R8: A write to the key address never raises `bank_wr_en`.
- R9: A non-key write between the two key bytes does not break the sequence. That write is itself blocked.
- R10: `rd_data` is zero when `rd_addr` equals the key address. Otherwise it equals `rd_bank_data`, combinationally.
- R11: Cycles with `wr_en` low leave the gate state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| rd_addr | input | ADDR_W | Bus read address |
| rd_bank_data | input | DATA_W | Read data from the protected bank |
| rd_data | output | DATA_W | Read data returned to the bus, zero at the key address |
| bank_wr_en | output | 1 | Qualified write enable for the protected bank |
| unlocked | output | 1 | High while protected writes are allowed |

## Verification
The assertions assume that the write strobe, address and data are stable and known around every clock edge. They also assume that a write lasts one cycle, so one strobe counts as one key attempt. The bench drives every input on the falling edge and holds each bus operation for exactly one cycle. Idle cycles separate the sequences, and the write data is fully defined, upper bits included, so that R6 is tested with non-zero high bits.

// File: rtl/wp_key_pkg.sv
// Shared types for the key-sequence write-protection gate.
// Assumes nothing beyond a two-bit state encoding.
package wp_key_pkg;
    typedef enum logic [1:0] {
        WK_CLOSED = 2'd0,
        WK_HALF   = 2'd1,
        WK_OPEN   = 2'd2
    } wk_state_t;
endpackage

// File: rtl/wp_key_match.sv
// Decodes one bus write into key events: a write to the key address, and
// whether its low key byte equals the first or the second key.
// Assumes a single-cycle write strobe.
module wp_key_match #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int KEY_W      = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h24,
    parameter logic [KEY_W-1:0]  KEY_FIRST  = 8'hCA,
    parameter logic [KEY_W-1:0]  KEY_SECOND = 8'h53
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_wr,
    output logic              plain_wr,
    output logic              is_first,
    output logic              is_second
);
    logic [KEY_W-1:0] key_byte;

    // Picks the compared key byte out of the write data.
    always_comb begin
        key_byte  = wr_data[KEY_W-1:0];
        key_wr    = wr_en && (wr_addr == KEY_ADDR);
        plain_wr  = wr_en && (wr_addr != KEY_ADDR);
        is_first  = (key_byte == KEY_FIRST);
        is_second = (key_byte == KEY_SECOND);
    end
endmodule

// File: rtl/wp_key_fsm.sv
// Three-state unlock sequencer. Closed -> half on the first key, half ->
// open on the second key. Any other key write, and any key write while
// open, returns it to closed. Non-key writes do not move it.
// Assumes key events decoded by wp_key_match.
module wp_key_fsm
    import wp_key_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      key_wr,
    input  logic      is_first,
    input  logic      is_second,
    output wk_state_t state
);
    wk_state_t state_nx;

    // Next-state choice for one key write.
    always_comb begin
        state_nx = state;
        if (key_wr) begin
            case (state)
                WK_CLOSED: state_nx = is_first  ? WK_HALF : WK_CLOSED;
                WK_HALF:   state_nx = is_second ? WK_OPEN : WK_CLOSED;
                default:   state_nx = WK_CLOSED;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WK_CLOSED;
        else        state <= state_nx;
    end
endmodule

// File: rtl/wp_wr_gate.sv
// Qualifies non-key writes with the open state.
// Assumes plain_wr already excludes the key address.
module wp_wr_gate
    import wp_key_pkg::*;
(
    input  wk_state_t state,
    input  logic      plain_wr,
    output logic      bank_wr_en,
    output logic      unlocked
);
    // Combinational write qualifier and open flag.
    always_comb begin
        unlocked   = (state == WK_OPEN);
        bank_wr_en = plain_wr && unlocked;
    end
endmodule

// File: rtl/wp_rd_mask.sv
// Forces the read data to zero at the key address. Every other address
// passes through unchanged.
module wp_rd_mask #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h24
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_bank_data,
    output logic [DATA_W-1:0] rd_data
);
    // Read-path mux.
    always_comb begin
        rd_data = (rd_addr == KEY_ADDR) ? '0 : rd_bank_data;
    end
endmodule

// File: rtl/wp_key_gate.sv
// Top of the write-protection gate. It decodes key writes, runs the
// unlock sequencer, gates bank writes and masks key reads.
// Assumes one bus write per cycle at most.
module wp_key_gate
    import wp_key_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int KEY_W      = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h24,
    parameter logic [KEY_W-1:0]  KEY_FIRST  = 8'hCA,
    parameter logic [KEY_W-1:0]  KEY_SECOND = 8'h53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_bank_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              bank_wr_en,
    output logic              unlocked
);
    logic      key_wr, plain_wr, is_first, is_second;
    wk_state_t state;

    wp_key_match #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
        .KEY_ADDR(KEY_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) u_match (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .key_wr(key_wr), .plain_wr(plain_wr),
        .is_first(is_first), .is_second(is_second)
    );

    wp_key_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
        .is_first(is_first), .is_second(is_second), .state(state)
    );

    wp_wr_gate u_gate (
        .state(state), .plain_wr(plain_wr),
        .bank_wr_en(bank_wr_en), .unlocked(unlocked)
    );

    wp_rd_mask #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR)
    ) u_rd (
        .rd_addr(rd_addr), .rd_bank_data(rd_bank_data), .rd_data(rd_data)
    );
endmodule

// File: rtl/wp_key_gate_chk.sv
// Port-level property checker for wp_key_gate, attached by bind.
// Assumes synchronous active-low reset and single-cycle writes.
module wp_key_gate_chk #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int KEY_W      = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h24,
    parameter logic [KEY_W-1:0]  KEY_FIRST  = 8'hCA,
    parameter logic [KEY_W-1:0]  KEY_SECOND = 8'h53
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              bank_wr_en,
    input logic              unlocked
);
    p_reset_closes_r1: assert property (@(posedge clk) !rst_n |=> !unlocked);

    p_open_needs_key2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && wr_addr == KEY_ADDR
                                  && wr_data[KEY_W-1:0] == KEY_SECOND));

    p_key_relocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && wr_en && wr_addr == KEY_ADDR) |=> !unlocked);

    p_closed_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> !bank_wr_en);

    p_key_not_forwarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == KEY_ADDR) |-> !bank_wr_en);

    p_key_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == KEY_ADDR) |-> (rd_data == '0));

    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(unlocked));
endmodule

bind wp_key_gate wp_key_gate_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .KEY_ADDR(KEY_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .bank_wr_en(bank_wr_en), .unlocked(unlocked)
);

// File: tb/test_wp_key_gate.sv
// Bench for wp_key_gate. A behavioural reference model is stepped once per
// clock and compared with all outputs before each rising edge.
module test_wp_key_gate;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] KA = 8'h24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_bank_data = '0;
    logic [DW-1:0] rd_data;
    logic          bank_wr_en;
    logic          unlocked;

    int n_cmp = 0;
    int n_bad = 0;
    int mstate = 0; // 0 closed, 1 first key seen, 2 open

    always #2 clk = ~clk;

    wp_key_gate i_wp_key_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_bank_data(rd_bank_data),
        .rd_data(rd_data), .bank_wr_en(bank_wr_en), .unlocked(unlocked)
    );

    task automatic cmp(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive, compare against the model, then advance the model.
    task automatic cyc(input string req, input logic rst, input logic we,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [AW-1:0] ra, input logic [DW-1:0] rb);
        logic          exp_open;
        logic          exp_we;
        logic [DW-1:0] exp_rd;
        @(negedge clk);
        rst_n = rst; wr_en = we; wr_addr = a; wr_data = d;
        rd_addr = ra; rd_bank_data = rb;
        #1;
        exp_open = (mstate == 2);
        exp_we   = we && (a != KA) && exp_open;
        exp_rd   = (ra == KA) ? '0 : rb;
        cmp(req, "unlocked", DW'(unlocked), DW'(exp_open));
        cmp(req, "bank_wr_en", DW'(bank_wr_en), DW'(exp_we));
        cmp(req, "rd_data", rd_data, exp_rd);
        if (!rst) mstate = 0;
        else if (we && a == KA) begin
            if (mstate == 0)      mstate = (d[7:0] == 8'hCA) ? 1 : 0;
            else if (mstate == 1) mstate = (d[7:0] == 8'h53) ? 2 : 0;
            else                  mstate = 0;
        end
    endtask

    task automatic kw(input string req, input logic [DW-1:0] d);
        cyc(req, 1'b1, 1'b1, KA, d, 8'h10, 32'h1234_5678);
    endtask

    task automatic pw(input string req, input logic [AW-1:0] a);
        cyc(req, 1'b1, 1'b1, a, 32'hA5A5_0001, a, 32'hDEAD_BEEF);
    endtask

    task automatic idle(input string req);
        cyc(req, 1'b1, 1'b0, 8'h08, 32'h0, 8'h0C, 32'h0BAD_F00D);
    endtask

    initial begin
        // R1: reset state
        cyc("R1", 1'b0, 1'b0, 8'h0, 32'h0, 8'h0, 32'h0);
        cyc("R1", 1'b0, 1'b1, KA, 32'hCA, 8'h0, 32'h0);
        idle("R1");
        // R7: closed gate blocks writes
        pw("R7", 8'h00);
        pw("R7", 8'h10);
        // R4: wrong first key keeps it closed
        kw("R4", 32'h53); kw("R4", 32'hFF); idle("R4");
        kw("R4", 32'h53);
        // R2: proper sequence opens
        kw("R2", 32'hCA); kw("R2", 32'h53); idle("R2");
        // R7: writes pass while open
        pw("R7", 8'h00); pw("R7", 8'h1C); pw("R7", 8'h10);
        // R8: key write is never forwarded, and it relocks (R5)
        kw("R8", 32'hFF); idle("R5"); pw("R5", 8'h04);
        // R3: wrong second key, including a repeated first key
        kw("R3", 32'hCA); kw("R3", 32'hCA); kw("R3", 32'h53); idle("R3");
        kw("R3", 32'hCA); kw("R3", 32'h00); pw("R3", 8'h08);
        // R9: non-key write between keys is blocked and keeps the sequence
        kw("R9", 32'hCA); pw("R9", 8'h08); idle("R9"); kw("R9", 32'h53);
        pw("R9", 8'h08);
        // R5: relock with keys themselves
        kw("R5", 32'hCA); pw("R5", 8'h00);
        kw("R5", 32'hCA); kw("R5", 32'h53); kw("R5", 32'h53); pw("R5", 8'h00);
        // R6: upper data bits ignored
        kw("R6", 32'hFFFF_FFCA); kw("R6", 32'h1234_0053); pw("R6", 8'h00);
        kw("R6", 32'h0000_01CA); pw("R6", 8'h00);
        kw("R6", 32'h0000_00CA); kw("R6", 32'hABCD_EF53); pw("R6", 8'h00);
        // R11: idle cycles hold the open state
        idle("R11"); idle("R11"); idle("R11"); pw("R11", 8'h00);
        // R10: key address reads zero, others pass through
        cyc("R10", 1'b1, 1'b0, 8'h0, 32'h0, KA, 32'hFFFF_FFFF);
        cyc("R10", 1'b1, 1'b0, 8'h0, 32'h0, 8'h25, 32'h5555_AAAA);
        // R1: reset while open closes
        cyc("R1", 1'b0, 1'b0, 8'h0, 32'h0, 8'h0, 32'h0);
        idle("R1"); pw("R1", 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule